// File: doc/BRIEF.md
# Debug memory window slave handshake

This block sits on the processor bus and claims requests whose address falls inside a fixed debug window. A claimed request is copied into an address record and, for writes, its payload into a data record. A pending flag is then raised and the bus transaction is kept open. The read or write finishes only when an external debugger has inspected the records, supplied read data where needed and written the pending flag back to zero. The handshake therefore runs on the debugger's timing, not the bus's. The debugger is modelled as a plain register port: a select, a write strobe, write data and combinational read data. The scan chain that would drive that port is not part of the block.

The requester holds `req_valid` and its fields until `bus_ready` pulses. On a read, that pulse comes with `rsp_valid` and the data, data code and modified flag taken from the data record. On a write, the pulse releases the held buffers so that the next window access can be claimed. The alternate debug exception vector lies inside the window, so instruction fetches from it are served through the same handshake.

Top module: `dbgwin_slave`

## Requirements
- R1: `req_claim` is 1 exactly when all four of these hold: `req_valid` is 1; the control enable bit (control bit 1) is 1; no transaction is open; and the full 40-bit `req_addr` lies between `WIN_BASE` and `WIN_LAST`, both ends included (defaults 0x00_1000_0000 and 0x00_1001_FFFF).
- R2: On the clock edge that ends a claiming cycle, the address record captures the request. Read through `dbg_sel`=0, it shows bit 53 write flag, bits 52:50 command, bits 49:48 cache attributes, bits 47:40 byte enables and bits 39:0 address, with zeros above bit 53.
- R3: On a claimed write, the same edge loads the data record. Read through `dbg_sel`=1, it shows bit 76 modified flag, bits 75:72 responder id, bits 71:64 data code and bits 63:0 data. The debugger may also write the data record through `dbg_sel`=1 using the same layout.
- R4: From the cycle after a claim, control bit 0 (the pending bit, read through `dbg_sel`=2) is 1.
- R5: On a read, when the debugger writes the control register with bit 0 at 0, `bus_ready` and `rsp_valid` are 1 for exactly the following cycle. In that cycle, `rsp_data`, `rsp_dcode` and `rsp_mod` equal the data record's data, data code and modified fields.
- R6: On a write, the same clearing gives one cycle of `bus_ready` with `rsp_valid` at 0. After that cycle, the pending bit reads 0 and a new window access is claimed.
- R7: An access to the alternate debug vector, address 0x00_1000_0480, is claimed and completes like any other window access.
- R8: While the pending bit is 1, `bus_ready` and `req_claim` stay 0. Window requests with changed fields leave the address record unchanged.
- R9: A debugger write to the control register that has bit 0 at 1 leaves the pending bit at 1 and does not complete the transaction. Control bit 1 always takes the written enable value.
- R10: After reset, `bus_ready`, `rsp_valid` and `req_claim` are 0, and the address, data and control registers all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request present, held until `bus_ready` |
| req_write | input | 1 | 1 for write, 0 for read or fetch |
| req_addr | input | 40 | Request address |
| req_cmd | input | 3 | Bus command |
| req_attr | input | 2 | Cache attributes |
| req_be | input | 8 | Byte enables |
| req_wdata | input | 64 | Write data |
| req_dcode | input | 8 | Write data code |
| req_rid | input | 4 | Responder id |
| req_mod | input | 1 | Modified flag |
| req_claim | output | 1 | Request accepted into the window this cycle |
| bus_ready | output | 1 | One-cycle completion of the open transaction |
| rsp_valid | output | 1 | Read data cycle |
| rsp_data | output | 64 | Read data |
| rsp_dcode | output | 8 | Read data code |
| rsp_mod | output | 1 | Read modified flag |
| dbg_sel | input | 2 | Debugger register select: 0 address, 1 data, 2 control |
| dbg_we | input | 1 | Debugger write strobe |
| dbg_wdata | input | 77 | Debugger write value |
| dbg_rdata | output | 77 | Debugger read value of the selected register |

## Verification
The bench builds the block with its default 40-bit window. It sweeps addresses one below, on and one above each window edge, the alternate vector, and an address that differs only in bit 39. This shows that the compare spans the full width and includes both ends. All 32 combinations of command and cache attribute are then run as alternating reads and writes across the window. Each one drives changed request fields and a control write that keeps the pending bit while the transaction is open.

// File: rtl/dbgwin_pkg.sv
package dbgwin_pkg;

    localparam int ADDR_W  = 40;
    localparam int DATA_W  = 64;
    localparam int BE_W    = DATA_W / 8;
    localparam int DCODE_W = 8;
    localparam int RID_W   = 4;
    localparam int CMD_W   = 3;
    localparam int ATTR_W  = 2;

    typedef struct packed {
        logic              wr;
        logic [CMD_W-1:0]  cmd;
        logic [ATTR_W-1:0] attr;
        logic [BE_W-1:0]   be;
        logic [ADDR_W-1:0] addr;
    } areg_t;

    typedef struct packed {
        logic               mod;
        logic [RID_W-1:0]   rid;
        logic [DCODE_W-1:0] dcode;
        logic [DATA_W-1:0]  data;
    } dreg_t;

    localparam int AREG_W = $bits(areg_t);
    localparam int DREG_W = $bits(dreg_t);
    localparam int DBG_W  = (DREG_W > AREG_W) ? DREG_W : AREG_W;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    localparam int CTL_PEND = 0;
    localparam int CTL_EN   = 1;

    typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_DONE} st_t;

    function automatic logic in_range(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] lo,
                                      input logic [ADDR_W-1:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

endpackage

// File: rtl/dbgwin_decode.sv
module dbgwin_decode
    import dbgwin_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE = 40'h00_1000_0000,
    parameter logic [ADDR_W-1:0] WIN_LAST = 40'h00_1001_FFFF
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    always_comb hit = in_range(addr, WIN_BASE, WIN_LAST);
endmodule

// File: rtl/dbgwin_ctrl.sv
module dbgwin_ctrl
    import dbgwin_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       win_hit,
    input  logic       dbg_we,
    input  logic [1:0] dbg_sel,
    input  logic [1:0] dbg_ctl_wr,
    output logic       claim,
    output logic       pend,
    output logic       en,
    output logic       bus_ready,
    output logic       rsp_valid
);
    st_t  st_q;
    logic pw_q;
    logic ctl_wr;

    always_comb begin
        ctl_wr    = dbg_we && (dbg_sel == SEL_CTRL);
        claim     = req_valid && win_hit && en && (st_q == ST_IDLE);
        bus_ready = (st_q == ST_DONE);
        rsp_valid = (st_q == ST_DONE) && !pw_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            pend <= 1'b0;
            en   <= 1'b0;
            pw_q <= 1'b0;
        end else begin
            if (ctl_wr) en <= dbg_ctl_wr[CTL_EN];
            case (st_q)
                ST_IDLE: if (claim) begin
                    st_q <= ST_HOLD;
                    pend <= 1'b1;
                    pw_q <= req_write;
                end
                ST_HOLD: if (ctl_wr && !dbg_ctl_wr[CTL_PEND]) begin
                    st_q <= ST_DONE;
                    pend <= 1'b0;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dbgwin_store.sv
module dbgwin_store
    import dbgwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic             cap_write,
    input  areg_t            areq,
    input  dreg_t            dreq,
    input  logic             dbg_we,
    input  logic [1:0]       dbg_sel,
    input  logic [DBG_W-1:0] dbg_wdata,
    input  logic [1:0]       ctl_bits,
    output areg_t            areg_q,
    output dreg_t            dreg_q,
    output logic [DBG_W-1:0] dbg_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            areg_q <= '0;
            dreg_q <= '0;
        end else begin
            if (capture) areg_q <= areq;
            if (capture && cap_write)
                dreg_q <= dreq;
            else if (dbg_we && dbg_sel == SEL_DATA)
                dreg_q <= dreg_t'(dbg_wdata[DREG_W-1:0]);
        end
    end

    always_comb begin
        case (dbg_sel)
            SEL_ADDR: dbg_rdata = DBG_W'(areg_q);
            SEL_DATA: dbg_rdata = DBG_W'(dreg_q);
            SEL_CTRL: dbg_rdata = DBG_W'(ctl_bits);
            default:  dbg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dbgwin_slave.sv
module dbgwin_slave
    import dbgwin_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE = 40'h00_1000_0000,
    parameter logic [ADDR_W-1:0] WIN_LAST = 40'h00_1001_FFFF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [CMD_W-1:0]   req_cmd,
    input  logic [ATTR_W-1:0]  req_attr,
    input  logic [BE_W-1:0]    req_be,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [DCODE_W-1:0] req_dcode,
    input  logic [RID_W-1:0]   req_rid,
    input  logic               req_mod,
    output logic               req_claim,
    output logic               bus_ready,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data,
    output logic [DCODE_W-1:0] rsp_dcode,
    output logic               rsp_mod,
    input  logic [1:0]         dbg_sel,
    input  logic               dbg_we,
    input  logic [DBG_W-1:0]   dbg_wdata,
    output logic [DBG_W-1:0]   dbg_rdata
);
    logic  win_hit;
    logic  pend_q;
    logic  en_q;
    areg_t areq;
    dreg_t dreq;
    areg_t areg_q;
    dreg_t dreg_q;

    always_comb begin
        areq = '{wr: req_write, cmd: req_cmd, attr: req_attr,
                 be: req_be, addr: req_addr};
        dreq = '{mod: req_mod, rid: req_rid, dcode: req_dcode,
                 data: req_wdata};
        rsp_data  = dreg_q.data;
        rsp_dcode = dreg_q.dcode;
        rsp_mod   = dreg_q.mod;
    end

    dbgwin_decode #(.WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST)) u_dec (
        .addr (req_addr),
        .hit  (win_hit)
    );

    dbgwin_ctrl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .win_hit    (win_hit),
        .dbg_we     (dbg_we),
        .dbg_sel    (dbg_sel),
        .dbg_ctl_wr (dbg_wdata[1:0]),
        .claim      (req_claim),
        .pend       (pend_q),
        .en         (en_q),
        .bus_ready  (bus_ready),
        .rsp_valid  (rsp_valid)
    );

    dbgwin_store u_st (
        .clk       (clk),
        .rst       (rst),
        .capture   (req_claim),
        .cap_write (req_write),
        .areq      (areq),
        .dreq      (dreq),
        .dbg_we    (dbg_we),
        .dbg_sel   (dbg_sel),
        .dbg_wdata (dbg_wdata),
        .ctl_bits  ({en_q, pend_q}),
        .areg_q    (areg_q),
        .dreg_q    (dreg_q),
        .dbg_rdata (dbg_rdata)
    );
endmodule

// File: rtl/dbgwin_checker.sv
module dbgwin_checker
    import dbgwin_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  claim,
    input logic  bus_ready,
    input logic  rsp_valid,
    input logic  pend,
    input areg_t areg
);
    AST_CLAIM_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
        claim |=> pend);                                   // R4
    AST_PEND_NO_READY: assert property (@(posedge clk) disable iff (rst)
        pend |-> !bus_ready);                              // R8
    AST_PEND_NO_CLAIM: assert property (@(posedge clk) disable iff (rst)
        pend |-> !claim);                                  // R8
    AST_PEND_HOLDS_ADDR: assert property (@(posedge clk) disable iff (rst)
        (pend && $past(pend)) |-> $stable(areg));          // R8
    AST_CLEAR_GIVES_READY: assert property (@(posedge clk) disable iff (rst)
        $fell(pend) |-> bus_ready);                        // R5
    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        bus_ready |=> !bus_ready);                         // R5
    AST_RSP_WITH_READY: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> bus_ready);                          // R5
endmodule

bind dbgwin_slave dbgwin_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .claim     (req_claim),
    .bus_ready (bus_ready),
    .rsp_valid (rsp_valid),
    .pend      (pend_q),
    .areg      (areg_q)
);

// File: tb/sim_dbgwin_slave.sv
`timescale 1ns/1ps
module sim_dbgwin_slave;
    import dbgwin_pkg::*;

    localparam logic [39:0] BASE = 40'h00_1000_0000;
    localparam logic [39:0] LAST = 40'h00_1001_FFFF;
    localparam logic [39:0] ALTV = 40'h00_1000_0480;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 0, req_write = 0, req_mod = 0;
    logic [39:0] req_addr = '0;
    logic [2:0]  req_cmd = '0;
    logic [1:0]  req_attr = '0;
    logic [7:0]  req_be = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0]  req_dcode = '0;
    logic [3:0]  req_rid = '0;
    logic req_claim, bus_ready, rsp_valid, rsp_mod;
    logic [63:0] rsp_data;
    logic [7:0]  rsp_dcode;
    logic [1:0]  dbg_sel = '0;
    logic        dbg_we = 0;
    logic [DBG_W-1:0] dbg_wdata = '0;
    logic [DBG_W-1:0] dbg_rdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dbgwin_slave u0 (.*);

    task automatic chk(input string tag, input logic [DBG_W-1:0] act,
                       input logic [DBG_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] s, output logic [DBG_W-1:0] v);
        dbg_sel = s;
        #1 v = dbg_rdata;
    endtask

    task automatic ctl_write(input logic [1:0] v);
        @(negedge clk);
        dbg_sel = SEL_CTRL; dbg_we = 1'b1; dbg_wdata = DBG_W'(v);
        @(negedge clk);
        dbg_we = 1'b0;
    endtask

    task automatic miss(input logic [39:0] a, input string tag);
        logic [DBG_W-1:0] v;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        #1 chk({tag, " claim"}, DBG_W'(req_claim), '0);
        @(negedge clk);
        rd(SEL_CTRL, v);
        chk({tag, " pend"}, DBG_W'(v[0]), '0);
        chk({tag, " ready"}, DBG_W'(bus_ready), '0);
        req_valid = 0;
    endtask

    task automatic txn(input logic [39:0] a, input logic wr, input logic [2:0] cm,
                       input logic [1:0] at, input logic [7:0] be, input logic [63:0] wd,
                       input logic [7:0] dc, input logic [3:0] ri, input logic md,
                       input string tag);
        logic [DBG_W-1:0] v, ea, ed, rsp;
        ea = DBG_W'({wr, cm, at, be, a});
        ed = DBG_W'({md, ri, dc, wd});
        rsp = DBG_W'({~md, ri ^ 4'h5, dc + 8'd3, wd ^ 64'hA5A5_5A5A_0F0F_F0F0});
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_cmd = cm; req_attr = at;
        req_be = be; req_wdata = wd; req_dcode = dc; req_rid = ri; req_mod = md;
        #1 chk({tag, " R1 claim"}, DBG_W'(req_claim), 1);
        @(negedge clk);
        rd(SEL_CTRL, v);  chk({tag, " R4 pend"}, DBG_W'(v[0]), 1);
        rd(SEL_ADDR, v);  chk({tag, " R2 addr rec"}, v, ea);
        if (wr) begin rd(SEL_DATA, v); chk({tag, " R3 data rec"}, v, ed); end
        chk({tag, " R8 ready"}, DBG_W'(bus_ready), '0);
        req_addr = a ^ 40'h10; req_be = ~be; req_cmd = ~cm;
        @(negedge clk);
        rd(SEL_ADDR, v);  chk({tag, " R8 no relatch"}, v, ea);
        chk({tag, " R8 claim"}, DBG_W'(req_claim), '0);
        ctl_write(2'b11);
        rd(SEL_CTRL, v);  chk({tag, " R9 pend kept"}, DBG_W'(v), 3);
        chk({tag, " R9 ready"}, DBG_W'(bus_ready), '0);
        if (!wr) begin
            @(negedge clk);
            dbg_sel = SEL_DATA; dbg_we = 1; dbg_wdata = rsp;
            @(negedge clk);
            dbg_we = 0;
        end
        req_addr = a; req_be = be; req_cmd = cm;
        ctl_write(2'b10);
        #1;
        chk({tag, wr ? " R6 ready" : " R5 ready"}, DBG_W'(bus_ready), 1);
        chk({tag, wr ? " R6 rsp_valid" : " R5 rsp_valid"}, DBG_W'(rsp_valid), DBG_W'(!wr));
        if (!wr) begin
            chk({tag, " R5 rsp fields"}, DBG_W'({rsp_mod, rsp_dcode, rsp_data}),
                DBG_W'({rsp[76], rsp[71:0]}));
        end
        @(negedge clk);
        req_valid = 0;
        rd(SEL_CTRL, v);  chk({tag, " R6 pend freed"}, DBG_W'(v[0]), '0);
        chk({tag, " R5 ready one cycle"}, DBG_W'(bus_ready), '0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DBG_W-1:0] v;
        logic [39:0] pts [9];
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10 reset state
        chk("R10 bus_ready", DBG_W'(bus_ready), '0);
        chk("R10 rsp_valid", DBG_W'(rsp_valid), '0);
        rd(SEL_ADDR, v); chk("R10 addr rec", v, '0);
        rd(SEL_DATA, v); chk("R10 data rec", v, '0);
        rd(SEL_CTRL, v); chk("R10 ctrl", v, '0);
        // R1 disabled: no claim even inside window
        miss(BASE, "R1 disabled base");
        miss(ALTV, "R1 disabled alt");
        ctl_write(2'b10);
        rd(SEL_CTRL, v); chk("R9 enable bit", v, 2);
        pts[0] = BASE - 1;   pts[1] = BASE;       pts[2] = BASE + 1;
        pts[3] = ALTV;       pts[4] = LAST - 1;   pts[5] = LAST;
        pts[6] = LAST + 1;   pts[7] = BASE | (40'h1 << 39); pts[8] = '0;
        for (int i = 0; i < 9; i++) begin
            if (pts[i] >= BASE && pts[i] <= LAST)
                txn(pts[i], i[0], 3'(i), 2'(i), 8'(8'h81 << i), 64'h1111_0000_0000_0000 * 64'(i + 1),
                    8'(i * 7), 4'(i), i[1], (pts[i] == ALTV) ? "R7 alt vector" : "R1 edge");
            else
                miss(pts[i], "R1 outside");
        end
        for (int k = 0; k < 32; k++) begin
            txn(BASE + 40'(k * 32'h1000) + 40'(k * 8), k[0], 3'(k), 2'(k >> 3),
                8'(8'h1 << (k % 8)) ^ 8'(k), {32'(k * 32'h9E37_79B9), 32'(~k)},
                8'(k * 13), 4'(k), k[2], "sweep");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule